// File: doc/BRIEF.md
# Addressable Latch with Demultiplex Mode

This block is a small addressable storage element with eight output bits. A 3-bit address picks one bit, a single data input supplies the value, and two control inputs pick one of four operating modes. The modes are: an active-low write enable and an active-high clear. With both low, only the addressed bit is written and the rest keep their values. With only the enable high, nothing is written. With only the clear high, the block acts as a 1-to-8 demultiplexer: the addressed output carries the data and all the others go low. With both high, every output is cleared.

The block is synchronous rather than transparent. On each rising edge of the system clock it samples the controls, the address and the data, and it updates its eight storage flops. A synchronous active-low reset clears all bits. A 2-bit debug output shows which mode the control inputs are selecting at that moment. The block is used for serial-to-parallel loading, for scattered bit updates, and as a registered demultiplexer.

Top module: `addr_store_latch`

## Requirements
- R1: Address value k (0 to 7) selects output bit q[k]. A change to a stored bit appears on q at the rising clock edge where the inputs were sampled.
- R2: With en_n=0 and clr=0 (write mode), the addressed bit takes din at the edge. Every other bit keeps its value.
- R3: With en_n=1 and clr=0 (hold mode), all eight bits keep their values. din and addr have no effect.
- R4: With en_n=0 and clr=1 (demultiplex mode), the addressed bit takes din at the edge and every other bit becomes 0.
- R5: With en_n=1 and clr=1 (clear mode), all eight bits become 0 at the edge, whatever the values of din and addr.
- R6: After demultiplex mode, hold mode keeps the zeros it stored in the unaddressed bits and keeps the last value of the addressed bit.
- R7: While rst_n=0 at a rising edge, all bits become 0. Reset takes priority over every mode, and q is 0 after reset.
- R8: mode_dbg is combinational and reports the selected mode as {clr, en_n}: 2'b00 write, 2'b01 hold, 2'b10 demultiplex, 2'b11 clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 3 | Selects which bit is written or routed |
| din | input | 1 | Data bit |
| en_n | input | 1 | Write enable, active low |
| clr | input | 1 | Clear / demultiplex select, active high |
| q | output | 8 | Stored bits |
| mode_dbg | output | 2 | Current mode code |

## Verification
The bench goes after the places where the two control inputs interact.

- **Clear with enable low.** A design that treats clear as a reset regardless of the enable would zero the routed bit in demultiplex mode, when that bit should carry din.
- **Return to hold after demultiplexing.** A design that kept shadow copies of the bits would restore stale ones when hold mode returns.
- **Hold mode with changing inputs.** A design that decodes hold mode too loosely would let din or addr leak into q.
- **Every address in demultiplex mode.** Sweeping all eight addresses would expose a decoder that swaps bit indices.
- **Reset during write mode.** Asserting reset while write mode is active would show a reset that has lower priority than the write.

// File: rtl/addr_store_latch_pkg.sv
package addr_store_latch_pkg;

  // Mode code is {clear, enable_n}
  typedef enum logic [1:0] {
    MODE_WRITE = 2'b00,
    MODE_HOLD  = 2'b01,
    MODE_DEMUX = 2'b10,
    MODE_CLEAR = 2'b11
  } mode_e;

  function automatic mode_e mode_from_ctrl(input logic enable_n, input logic clear);
    mode_e m;
    case ({clear, enable_n})
      2'b00:   m = MODE_WRITE;
      2'b01:   m = MODE_HOLD;
      2'b10:   m = MODE_DEMUX;
      default: m = MODE_CLEAR;
    endcase
    return m;
  endfunction

  // Next value of one stored bit given its controls
  function automatic logic bit_next(input logic cur, input logic load,
                                    input logic zero, input logic d);
    logic n;
    if (zero)      n = 1'b0;
    else if (load) n = d;
    else           n = cur;
    return n;
  endfunction

endpackage

// File: rtl/asl_mode_decode.sv
module asl_mode_decode
  import addr_store_latch_pkg::*;
(
  input  logic  en_n,
  input  logic  clr,
  output mode_e mode,
  output logic  load_ok,
  output logic  zero_unsel,
  output logic  zero_all
);

  always_comb begin
    mode       = mode_from_ctrl(en_n, clr);
    load_ok    = 1'b0;
    zero_unsel = 1'b0;
    zero_all   = 1'b0;
    case (mode)
      MODE_WRITE: load_ok = 1'b1;
      MODE_DEMUX: begin
        load_ok    = 1'b1;
        zero_unsel = 1'b1;
      end
      MODE_CLEAR: zero_all = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/asl_addr_decode.sv
module asl_addr_decode #(
  parameter int ADDR_W = 3,
  localparam int NB = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NB-1:0]     sel
);

  for (genvar i = 0; i < NB; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/asl_bit_cell.sv
module asl_bit_cell
  import addr_store_latch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic zero,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= bit_next(q, load, zero, d);
  end

endmodule

// File: rtl/addr_store_latch.sv
module addr_store_latch
  import addr_store_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NB = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  input  logic              en_n,
  input  logic              clr,
  output logic [NB-1:0]     q,
  output logic [1:0]        mode_dbg
);

  mode_e         mode;
  logic          load_ok;
  logic          zero_unsel;
  logic          zero_all;
  logic [NB-1:0] addr_sel;
  logic [NB-1:0] bit_load;
  logic [NB-1:0] bit_zero;

  asl_mode_decode u_mode (
    .en_n       (en_n),
    .clr        (clr),
    .mode       (mode),
    .load_ok    (load_ok),
    .zero_unsel (zero_unsel),
    .zero_all   (zero_all)
  );

  asl_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (addr_sel)
  );

  for (genvar i = 0; i < NB; i++) begin : g_bit
    assign bit_load[i] = load_ok & addr_sel[i];
    assign bit_zero[i] = zero_all | (zero_unsel & ~addr_sel[i]);

    asl_bit_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (bit_load[i]),
      .zero  (bit_zero[i]),
      .d     (din),
      .q     (q[i])
    );
  end

  assign mode_dbg = mode;

endmodule

// File: rtl/addr_store_latch_chk.sv
module addr_store_latch_chk #(
  parameter int ADDR_W = 3,
  localparam int NB = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              din,
  input logic              en_n,
  input logic              clr,
  input logic [NB-1:0]     q,
  input logic [1:0]        mode_dbg
);

  localparam logic [NB-1:0] ONE = NB'(1);

  // R2 / R1: addressed bit takes din
  p_write_addressed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !clr) |=> (q[$past(addr)] == $past(din)));

  // R2: unaddressed bits keep their values
  p_write_others_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !clr) |=> (((q ^ $past(q)) & ~(ONE << $past(addr))) == '0));

  // R3: hold mode keeps every bit
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n && !clr) |=> $stable(q));

  // R4: demultiplex leaves at most one bit set, at the routed place
  p_demux_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && clr) |=> ($onehot0(q) && (q[$past(addr)] == $past(din))));

  // R5: clear zeroes everything
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n && clr) |=> (q == '0));

  // R8: mode code reflects the control pins
  p_mode_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n && clr) |-> (mode_dbg == 2'b11));
  p_mode_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !clr) |-> (mode_dbg == 2'b00));

endmodule

bind addr_store_latch addr_store_latch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .din      (din),
  .en_n     (en_n),
  .clr      (clr),
  .q        (q),
  .mode_dbg (mode_dbg)
);

// File: tb/tb_addr_store_latch.sv
`timescale 1ns/1ps
module tb_addr_store_latch;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       din = 1'b0;
  logic       en_n = 1'b1;
  logic       clr = 1'b0;
  logic [7:0] q;
  logic [1:0] mode_dbg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  addr_store_latch dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .en_n(en_n), .clr(clr), .q(q), .mode_dbg(mode_dbg)
  );

  // {en_n, clr, addr, din, expected q, expected mode}
  typedef logic [15:0] vec_t;
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    {1'b0, 1'b0, 3'd0, 1'b1, 8'h01, 2'b00},
    {1'b0, 1'b0, 3'd3, 1'b1, 8'h09, 2'b00},
    {1'b0, 1'b0, 3'd7, 1'b1, 8'h89, 2'b00},
    {1'b0, 1'b0, 3'd0, 1'b0, 8'h88, 2'b00},
    {1'b1, 1'b0, 3'd5, 1'b1, 8'h88, 2'b01},
    {1'b1, 1'b0, 3'd0, 1'b1, 8'h88, 2'b01},
    {1'b0, 1'b0, 3'd5, 1'b1, 8'hA8, 2'b00},
    {1'b0, 1'b1, 3'd2, 1'b1, 8'h04, 2'b10},
    {1'b0, 1'b1, 3'd2, 1'b0, 8'h00, 2'b10},
    {1'b0, 1'b1, 3'd6, 1'b1, 8'h40, 2'b10},
    {1'b1, 1'b0, 3'd1, 1'b0, 8'h40, 2'b01},
    {1'b0, 1'b0, 3'd1, 1'b1, 8'h42, 2'b00},
    {1'b1, 1'b1, 3'd3, 1'b1, 8'h00, 2'b11},
    {1'b0, 1'b0, 3'd7, 1'b1, 8'h80, 2'b00},
    {1'b0, 1'b0, 3'd6, 1'b1, 8'hC0, 2'b00},
    {1'b1, 1'b0, 3'd7, 1'b0, 8'hC0, 2'b01},
    {1'b1, 1'b1, 3'd0, 1'b1, 8'h00, 2'b11}
  };

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check_q(input string req, input logic [7:0] exp);
    checks++;
    if (q !== exp) begin
      fails++;
      $display("FAIL %s: q=%h expected %h", req, q, exp);
    end
  endtask

  task automatic check_mode(input logic [1:0] exp);
    checks++;
    if (mode_dbg !== exp) begin
      fails++;
      $display("FAIL R8: mode_dbg=%b expected %b", mode_dbg, exp);
    end
  endtask

  // drive at negedge, check mode after settle, check q after the edge
  task automatic step(input logic e, input logic c, input logic [2:0] a, input logic d);
    @(negedge clk);
    en_n = e; clr = c; addr = a; din = d;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    repeat (3) @(posedge clk);
    #1;
    check_q("R7 reset state", 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk (R2..R6, R8); vector 10 is the R6 hold after demultiplex
    for (int i = 0; i < NV; i++) begin
      step(VECS[i][15], VECS[i][14], VECS[i][13:11], VECS[i][10]);
      check_mode(VECS[i][1:0]);
      @(posedge clk); #1;
      check_q((i == 10) ? "R6" : tag_of(VECS[i][1:0]), VECS[i][9:2]);
    end

    // R1: demultiplex sweep across all addresses
    for (int a = 0; a < 8; a++) begin
      step(1'b0, 1'b1, 3'(a), 1'b1);
      @(posedge clk); #1;
      check_q("R1 demux sweep", 8'(1) << a);
    end

    // R3: hold mode ignores many din/addr combinations (q = 0x80 from sweep)
    for (int a = 0; a < 8; a++) begin
      step(1'b1, 1'b0, 3'(a), a[0]);
      @(posedge clk); #1;
      check_q("R3 hold ignores inputs", 8'h80);
    end

    // R5: clear with din low and another address
    step(1'b1, 1'b1, 3'd7, 1'b0);
    check_mode(2'b11);
    @(posedge clk); #1;
    check_q("R5 clear", 8'h00);

    // R7: reset wins over write mode
    step(1'b0, 1'b0, 3'd4, 1'b1);
    @(posedge clk); #1;
    check_q("R2 write before reset", 8'h10);
    step(1'b0, 1'b0, 3'd2, 1'b1);
    rst_n = 1'b0;
    @(posedge clk); #1;
    check_q("R7 reset priority", 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    en_n = 1'b1;
    @(posedge clk); #1;
    check_q("R7 after reset hold", 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule